// File: doc/BRIEF.md
# Indexed Configuration Register Space

This block holds the chip-wide configuration registers behind a two-location host window. The host writes a register number to the index location, then reads or writes the selected register through the data location. The registers can only be reached while configuration mode is open. Writing a key byte to the index location opens configuration mode, and a second key byte closes it.

The space contains a write-only soft-reset trigger, a logical device number, a general control byte and a power byte for the first serial ports. For each serial port there is also an activate bit, which is reached at one index through the logical device number. From these bits the block derives, for each serial port, a power-good flag and an output enable. The output enable is also gated by the pin-mux select of that port's shared pin.

Every register belongs to a reset domain. Supply power-on, standby power-on and bus reset all act as a hard reset. Some registers are also cleared by the soft reset.

Top module: `cfg_index_space`

## Requirements
- R1: A low level on any of `sup_por_n`, `stby_por_n` or `bus_rst_n` at a clock edge resets the block. Configuration mode closes, `dev_sel` becomes 0x00, the general control byte becomes 0x00, the power byte becomes 0x03, every activate bit becomes 0, and `uart_pwr_good` and `uart_oe` become all zeros.
- R2: An index write of 0x55 opens configuration mode and an index write of 0xAA closes it. Neither key byte changes the latched index. Any other index write latches the byte as the register number.
- R3: While configuration mode is closed, data-port writes change no register and data-port reads return 0x00.
- R4: The decode compares all 8 bits of the index. Index 0x87 does not reach index 0x07. Unimplemented indices, for example 0x05 and 0x1C, drop writes and read 0x00.
- R5: Index 0x07 holds the 8-bit logical device number. It can be read and written, and it appears on `dev_sel`.
- R6: Writing a byte with bit 0 set to index 0x02 raises a one-clock internal soft-reset pulse. On the next edge the pulse clears the logical device number and all activate bits. Index 0x02 always reads 0x00.
- R7: Index 0x19 is an 8-bit read/write general control byte. The soft reset does not change it.
- R8: At index 0x22, bit 0 is the power bit of serial port 1 and bit 1 is the power bit of port 2. Bits 7:2 read 0. The soft reset does not change this byte.
- R9: At index 0x30, bit 0 is the activate bit of serial port k (k = 1..6) while the logical device number equals 3+k, so port 1 is device 4 and port 6 is device 9. Bits 7:1 read 0. For any other device number, index 0x30 drops writes and reads 0x00.
- R10: `uart_pwr_good[0]` and `uart_pwr_good[1]` require both the activate bit and the power bit of their port. Bits 2 to 5 require only the activate bit.
- R11: `uart_oe[i]` equals `uart_pwr_good[i]` AND `mux_sel[i]`. It follows a register write directly after the edge that performs the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sup_por_n | input | 1 | Supply power-on reset, active low, synchronous |
| stby_por_n | input | 1 | Standby power-on reset, active low, synchronous |
| bus_rst_n | input | 1 | Host bus reset, active low, synchronous |
| sel_data | input | 1 | 0 selects the index location, 1 selects the data location |
| wr_en | input | 1 | Write strobe, sampled on the clock edge |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while `rd_en` is high |
| mux_sel | input | 6 | For each port, high when the serial port is the selected function on its shared pin |
| cfg_mode | output | 1 | Configuration mode open |
| dev_sel | output | 8 | Current logical device number |
| uart_pwr_good | output | 6 | For each port, the port is powered (not in powerdown) |
| uart_oe | output | 6 | For each port, output enable for the serial port outputs |

## Verification
The hardest case to reach is the soft reset. Its pulse lives one cycle inside the block and has to be seen through what it clears. At the same time, the registers it must leave alone have to keep their values. To get there, the stimulus first loads a device number, a control byte, a cleared power byte and two activate bits on different device numbers. It then fires the trigger and reads every register back through the data port. It also checks that configuration mode stays open.

// File: rtl/cfg_index_pkg.sv
// Package: register indices and key bytes shared by the configuration space.
// Assumes an 8-bit index and data path throughout.
package cfg_index_pkg;
    localparam int DW = 8;
    localparam logic [DW-1:0] IDX_SRST = 8'h02;
    localparam logic [DW-1:0] IDX_LDN  = 8'h07;
    localparam logic [DW-1:0] IDX_GCTL = 8'h19;
    localparam logic [DW-1:0] IDX_PWR  = 8'h22;
    localparam logic [DW-1:0] IDX_ACT  = 8'h30;
    localparam logic [DW-1:0] KEY_OPEN  = 8'h55;
    localparam logic [DW-1:0] KEY_CLOSE = 8'hAA;
endpackage

// File: rtl/cfg_host_port.sv
// Host window: latches the index, tracks configuration mode and qualifies
// data-port strobes with it. Assumes strobes are single-cycle, synchronous to clk.
module cfg_host_port
    import cfg_index_pkg::*;
(
    input  logic          clk,
    input  logic          hard_rst_n,
    input  logic          sel_data,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [DW-1:0] wdata,
    output logic          cfg_mode,
    output logic [DW-1:0] idx,
    output logic          dwr,
    output logic          drd
);
    logic idx_wr;
    logic is_key;

    // Purpose: classify index-port writes.
    always_comb begin
        idx_wr = wr_en && !sel_data;
        is_key = (wdata == KEY_OPEN) || (wdata == KEY_CLOSE);
    end

    // Purpose: track configuration mode from the key bytes.
    always_ff @(posedge clk) begin
        if (!hard_rst_n)
            cfg_mode <= 1'b0;
        else if (idx_wr && wdata == KEY_OPEN)
            cfg_mode <= 1'b1;
        else if (idx_wr && wdata == KEY_CLOSE)
            cfg_mode <= 1'b0;
    end

    // Purpose: latch the register number; key bytes leave it unchanged.
    always_ff @(posedge clk) begin
        if (!hard_rst_n)
            idx <= '0;
        else if (idx_wr && !is_key)
            idx <= wdata;
    end

    // Purpose: data-port strobes pass only inside configuration mode.
    always_comb begin
        dwr = wr_en && sel_data && cfg_mode;
        drd = rd_en && sel_data && cfg_mode;
    end
endmodule

// File: rtl/cfg_global_regs.sv
// Global registers: soft-reset trigger, logical device number, general control
// byte and the power byte. Assumes dwr is already gated by configuration mode.
module cfg_global_regs
    import cfg_index_pkg::*;
#(
    parameter int N_PWR = 2
) (
    input  logic             clk,
    input  logic             hard_rst_n,
    input  logic             dwr,
    input  logic [DW-1:0]    idx,
    input  logic [DW-1:0]    wdata,
    output logic             soft_pulse,
    output logic [DW-1:0]    ldn,
    output logic [DW-1:0]    gctl,
    output logic [N_PWR-1:0] pwr
);
    // Purpose: one-clock soft-reset pulse from the write-only trigger.
    always_ff @(posedge clk) begin
        if (!hard_rst_n)
            soft_pulse <= 1'b0;
        else
            soft_pulse <= dwr && (idx == IDX_SRST) && wdata[0];
    end

    // Purpose: logical device number, cleared by hard and soft reset.
    always_ff @(posedge clk) begin
        if (!hard_rst_n || soft_pulse)
            ldn <= '0;
        else if (dwr && idx == IDX_LDN)
            ldn <= wdata;
    end

    // Purpose: general control byte, hard reset domain only.
    always_ff @(posedge clk) begin
        if (!hard_rst_n)
            gctl <= '0;
        else if (dwr && idx == IDX_GCTL)
            gctl <= wdata;
    end

    // Purpose: power bits of the gated ports, reset to powered, hard domain only.
    always_ff @(posedge clk) begin
        if (!hard_rst_n)
            pwr <= '1;
        else if (dwr && idx == IDX_PWR)
            pwr <= wdata[N_PWR-1:0];
    end
endmodule

// File: rtl/cfg_port_gate.sv
// Per-port activate bits reached through the device number, and the derived
// power-good and output-enable flags. Assumes N_PWR <= N_PORTS.
module cfg_port_gate
    import cfg_index_pkg::*;
#(
    parameter int N_PORTS  = 6,
    parameter int N_PWR    = 2,
    parameter int LDN_BASE = 4
) (
    input  logic               clk,
    input  logic               hard_rst_n,
    input  logic               soft_pulse,
    input  logic               dwr,
    input  logic [DW-1:0]      idx,
    input  logic               wbit,
    input  logic [DW-1:0]      ldn,
    input  logic [N_PWR-1:0]   pwr,
    input  logic [N_PORTS-1:0] mux_sel,
    output logic               act_hit,
    output logic               act_rd,
    output logic [N_PORTS-1:0] pwr_good,
    output logic [N_PORTS-1:0] oe
);
    logic [N_PORTS-1:0] act;
    logic [N_PORTS-1:0] sel;

    for (genvar k = 0; k < N_PORTS; k++) begin : g_port
        // Purpose: this port's device is the one currently selected.
        assign sel[k] = (ldn == DW'(LDN_BASE + k));

        // Purpose: activate bit, cleared by hard and soft reset.
        always_ff @(posedge clk) begin
            if (!hard_rst_n || soft_pulse)
                act[k] <= 1'b0;
            else if (dwr && idx == IDX_ACT && sel[k])
                act[k] <= wbit;
        end

        // Purpose: power-good needs the power bit only on the gated ports.
        if (k < N_PWR) begin : g_pwr
            assign pwr_good[k] = act[k] && pwr[k];
        end else begin : g_act_only
            assign pwr_good[k] = act[k];
        end

        // Purpose: drive outputs only when the port owns its shared pin.
        assign oe[k] = pwr_good[k] && mux_sel[k];
    end

    // Purpose: readback of the selected device's activate bit.
    always_comb begin
        act_hit = |sel;
        act_rd  = |(sel & act);
    end
endmodule

// File: rtl/cfg_index_space.sv
// Top: indexed configuration space with hard and soft reset domains.
// Assumes all three reset inputs are synchronous to clk.
module cfg_index_space
    import cfg_index_pkg::*;
#(
    parameter int N_PORTS  = 6,
    parameter int N_PWR    = 2,
    parameter int LDN_BASE = 4
) (
    input  logic               clk,
    input  logic               sup_por_n,
    input  logic               stby_por_n,
    input  logic               bus_rst_n,
    input  logic               sel_data,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [7:0]         wdata,
    output logic [7:0]         rdata,
    input  logic [N_PORTS-1:0] mux_sel,
    output logic               cfg_mode,
    output logic [7:0]         dev_sel,
    output logic [N_PORTS-1:0] uart_pwr_good,
    output logic [N_PORTS-1:0] uart_oe
);
    logic             hard_rst_n;
    logic [DW-1:0]    idx;
    logic             dwr;
    logic             drd;
    logic             soft_pulse;
    logic [DW-1:0]    gctl;
    logic [N_PWR-1:0] pwr;
    logic             act_hit;
    logic             act_rd;

    // Purpose: any of the three hard sources resets the hard domain.
    assign hard_rst_n = sup_por_n && stby_por_n && bus_rst_n;

    cfg_host_port u_host (
        .clk(clk), .hard_rst_n(hard_rst_n), .sel_data(sel_data),
        .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
        .cfg_mode(cfg_mode), .idx(idx), .dwr(dwr), .drd(drd)
    );

    cfg_global_regs #(.N_PWR(N_PWR)) u_glb (
        .clk(clk), .hard_rst_n(hard_rst_n), .dwr(dwr), .idx(idx),
        .wdata(wdata), .soft_pulse(soft_pulse), .ldn(dev_sel),
        .gctl(gctl), .pwr(pwr)
    );

    cfg_port_gate #(.N_PORTS(N_PORTS), .N_PWR(N_PWR), .LDN_BASE(LDN_BASE)) u_gate (
        .clk(clk), .hard_rst_n(hard_rst_n), .soft_pulse(soft_pulse),
        .dwr(dwr), .idx(idx), .wbit(wdata[0]), .ldn(dev_sel), .pwr(pwr),
        .mux_sel(mux_sel), .act_hit(act_hit), .act_rd(act_rd),
        .pwr_good(uart_pwr_good), .oe(uart_oe)
    );

    // Purpose: full-width read decode; everything unimplemented returns zero.
    always_comb begin
        rdata = '0;
        if (drd) begin
            case (idx)
                IDX_LDN:  rdata = dev_sel;
                IDX_GCTL: rdata = gctl;
                IDX_PWR:  rdata = DW'(pwr);
                IDX_ACT:  rdata = {7'b0, act_hit && act_rd};
                default:  rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/cfg_index_space_chk.sv
// Checker for cfg_index_space, attached by bind. Observes ports and the
// latched index and soft pulse.
module cfg_index_space_chk #(
    parameter int N_PORTS = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_mode,
    input logic               sel_data,
    input logic               wr_en,
    input logic [7:0]         wdata,
    input logic [7:0]         idx,
    input logic [7:0]         rdata,
    input logic               soft_pulse,
    input logic [7:0]         dev_sel,
    input logic [N_PORTS-1:0] mux_sel,
    input logic [N_PORTS-1:0] pwr_good,
    input logic [N_PORTS-1:0] oe
);
    assert_key_keeps_idx_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sel_data && (wdata == 8'h55 || wdata == 8'hAA)) |=> $stable(idx));

    assert_closed_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_mode |-> rdata == 8'h00);

    assert_closed_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_mode && wr_en && sel_data) |=> $stable(dev_sel));

    assert_soft_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        soft_pulse |=> !soft_pulse);

    assert_soft_clears_ldn_R6: assert property (@(posedge clk) disable iff (!rst_n)
        soft_pulse |=> dev_sel == 8'h00);

    assert_oe_needs_mux_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (oe & ~mux_sel) == '0);

    assert_oe_needs_power_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (oe & ~pwr_good) == '0);
endmodule

bind cfg_index_space cfg_index_space_chk #(.N_PORTS(N_PORTS)) u_chk (
    .clk(clk), .rst_n(hard_rst_n), .cfg_mode(cfg_mode), .sel_data(sel_data),
    .wr_en(wr_en), .wdata(wdata), .idx(idx), .rdata(rdata),
    .soft_pulse(soft_pulse), .dev_sel(dev_sel), .mux_sel(mux_sel),
    .pwr_good(uart_pwr_good), .oe(uart_oe)
);

// File: tb/cfg_index_space_bench.sv
// Scoreboard bench: read tasks queue expected bytes, a monitor compares them.
module cfg_index_space_bench;
    logic       clk = 1'b0;
    logic       sup_por_n = 1'b0, stby_por_n = 1'b0, bus_rst_n = 1'b0;
    logic       sel_data = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [5:0] mux_sel = 6'h3F;
    logic       cfg_mode;
    logic [7:0] dev_sel;
    logic [5:0] uart_pwr_good, uart_oe;

    int    n_checks = 0, n_errors = 0;
    bit    done = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    cfg_index_space u_cfg_index_space (
        .clk(clk), .sup_por_n(sup_por_n), .stby_por_n(stby_por_n),
        .bus_rst_n(bus_rst_n), .sel_data(sel_data), .wr_en(wr_en),
        .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .mux_sel(mux_sel),
        .cfg_mode(cfg_mode), .dev_sel(dev_sel),
        .uart_pwr_good(uart_pwr_good), .uart_oe(uart_oe)
    );

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // Monitor: pops one expected byte per data-port read, away from the edge.
    always @(negedge clk) begin
        if (rd_en && sel_data) begin
            if (exp_q.size() == 0) begin
                n_checks++; n_errors++;
                $display("FAIL scoreboard: actual %02h expected none", rdata);
            end else begin
                check(tag_q.pop_front(), rdata, exp_q.pop_front());
            end
        end
    end

    task automatic wr_port(bit data, logic [7:0] v);
        @(posedge clk); #1;
        sel_data = data; wdata = v; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic wr_reg(logic [7:0] i, logic [7:0] v);
        wr_port(0, i);
        wr_port(1, v);
    endtask

    task automatic rd_reg(logic [7:0] i, logic [7:0] exp, string tag);
        wr_port(0, i);
        @(posedge clk); #1;
        sel_data = 1'b1; rd_en = 1'b1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic hard_reset(bit all);
        @(posedge clk); #1;
        bus_rst_n = 1'b0;
        if (all) begin sup_por_n = 1'b0; stby_por_n = 1'b0; end
        repeat (3) @(posedge clk);
        #1;
        sup_por_n = 1'b1; stby_por_n = 1'b1; bus_rst_n = 1'b1;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        hard_reset(1);
        check("R1 cfg_mode", {7'b0, cfg_mode}, 8'h00);
        check("R1 dev_sel", dev_sel, 8'h00);
        check("R1 pwr_good", {2'b0, uart_pwr_good}, 8'h00);
        check("R1 oe", {2'b0, uart_oe}, 8'h00);

        // R3: closed-mode access is dropped and reads zero
        wr_reg(8'h07, 8'h5A);
        rd_reg(8'h07, 8'h00, "R3 closed read");
        check("R3 dev_sel unchanged", dev_sel, 8'h00);

        // R2: open, keys keep the index
        wr_port(0, 8'h55);
        check("R2 open", {7'b0, cfg_mode}, 8'h01);
        rd_reg(8'h07, 8'h00, "R3 closed write dropped");
        wr_port(0, 8'h55);
        wr_port(1, 8'h12);
        rd_reg(8'h07, 8'h12, "R2 key keeps index");
        check("R5 dev_sel", dev_sel, 8'h12);

        // R4: full decode and unimplemented locations
        wr_reg(8'h87, 8'hFF);
        rd_reg(8'h87, 8'h00, "R4 alias read");
        rd_reg(8'h07, 8'h12, "R4 no alias");
        wr_reg(8'h05, 8'hFF);
        rd_reg(8'h05, 8'h00, "R4 reserved 05");
        wr_reg(8'h1C, 8'hFF);
        rd_reg(8'h1C, 8'h00, "R4 reserved 1C");

        // R7, R8
        wr_reg(8'h19, 8'hA5);
        rd_reg(8'h19, 8'hA5, "R7 gctl");
        rd_reg(8'h22, 8'h03, "R8 pwr reset");
        wr_reg(8'h22, 8'hFF);
        rd_reg(8'h22, 8'h03, "R8 pwr upper bits");

        // R9, R10, R11: port 1 (device 4) and port 3 (device 6)
        wr_reg(8'h07, 8'h04);
        wr_reg(8'h30, 8'hFF);
        check("R11 oe same cycle", {2'b0, uart_oe}, 8'h01);
        rd_reg(8'h30, 8'h01, "R9 act port1");
        wr_reg(8'h07, 8'h06);
        wr_reg(8'h30, 8'h01);
        check("R9 pwr_good", {2'b0, uart_pwr_good}, 8'h05);
        wr_reg(8'h07, 8'h02);
        wr_reg(8'h30, 8'h01);
        rd_reg(8'h30, 8'h00, "R9 non-serial device");
        check("R9 non-serial no effect", {2'b0, uart_pwr_good}, 8'h05);
        wr_reg(8'h22, 8'h00);
        check("R10 power gating", {2'b0, uart_pwr_good}, 8'h04);
        #1 mux_sel = 6'h3B;
        #1 check("R11 mux gating", {2'b0, uart_oe}, 8'h00);
        mux_sel = 6'h3F;
        #1 check("R11 mux restore", {2'b0, uart_oe}, 8'h04);

        // R6: soft reset
        wr_reg(8'h07, 8'h33);
        wr_reg(8'h02, 8'h01);
        rd_reg(8'h02, 8'h00, "R6 write-only");
        check("R6 ldn cleared", dev_sel, 8'h00);
        check("R6 act cleared", {2'b0, uart_pwr_good}, 8'h00);
        check("R6 mode kept", {7'b0, cfg_mode}, 8'h01);
        rd_reg(8'h19, 8'hA5, "R7 soft keeps gctl");
        rd_reg(8'h22, 8'h00, "R8 soft keeps pwr");

        // R2: close
        wr_port(0, 8'hAA);
        check("R2 close", {7'b0, cfg_mode}, 8'h00);

        // R1: bus reset alone
        wr_port(0, 8'h55);
        wr_reg(8'h07, 8'h09);
        hard_reset(0);
        check("R1 bus reset mode", {7'b0, cfg_mode}, 8'h00);
        check("R1 bus reset ldn", dev_sel, 8'h00);
        wr_port(0, 8'h55);
        rd_reg(8'h19, 8'h00, "R1 gctl reset");
        rd_reg(8'h22, 8'h03, "R1 pwr reset");

        repeat (2) @(posedge clk);
        if (exp_q.size() != 0) begin
            n_checks++; n_errors++;
            $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule